// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a display: horizontal and vertical sync, a data-enable strobe, and the pixel column and row inside the visible area. Every interval on both axes is a register-programmed length, so one design serves any resolution and blanking scheme that fits the counter width. A small synchronous register port lets software program the timing, choose the active level of each output, start or stop the raster, and handle two interrupt sources.

The horizontal axis advances once per clock and the vertical axis once per finished line. Each axis walks through sync pulse, back porch, active data and front porch, then repeats. An interrupt line reports the start of each frame's vertical sync and any pulse on an external underrun strobe. The strobe stands in for the pixel fetch path, which sits outside this block.

The register map uses 4-bit word addresses. 0x0 is the command register (bit 0 enables the raster). 0x1 is polarity. 0x2 is the interrupt mask. 0x3 is the interrupt status, which is read-only. 0x4 is interrupt clear, which is write-only and reads as zero. 0x8 to 0xB hold the horizontal intervals and 0xC to 0xF hold the vertical intervals. Within each group of four, the offsets 0, 1, 2 and 3 select sync, back porch, active and front porch. Read data is registered and appears one clock after the address is presented.

Top module: `vtg_top`

## Requirements
- R1: Each axis visits its intervals in the fixed order sync, back porch, active, front porch, then returns to sync. The horizontal axis steps once per clock and the vertical axis steps once per completed line. With the block enabled by a write at edge E, the outputs after edge E+n show raster clock n-1 of the frame.
- R2: An interval register holds the interval length minus one. A value of 0 gives one clock on the horizontal axis or one line on the vertical axis.
- R3: Data-enable is active only when both axes are in their active intervals. In that area, x_o and y_o count from 0 at the first active clock and line. Outside it, both read 0.
- R4: When command bit 0 is 0, hsync, vsync and data-enable sit at their inactive levels and x_o and y_o are 0. This holds from the second edge after the disabling write. The counters are also reset, so a new enable restarts at the first clock of the frame.
- R5: In the polarity register, bit 0 is hsync, bit 1 is vsync, bit 2 is data-enable, bit 3 is pixel clock and bit 4 is data. A set bit makes that signal active-high. Bits 3 and 4 are driven out on pclk_pol_o and data_pol_o. After reset, all five bits are 1.
- R6: Status bit 0 is set on the first clock of each frame's vertical sync, including the first frame after enabling. Status bit 1 is set by any clock with underrun_i high. Status bits are set whatever the mask holds.
- R7: Writing 1 to a bit of the clear register clears that status bit, and writing 0 leaves it unchanged. If a clear and a new event hit the same bit in one clock, the bit stays set.
- R8: irq_o is high exactly while some status bit is set and its mask bit is 1. The mask uses the same bit positions as status.
- R9: The command, polarity, mask and interval registers read back the last value written. The status register reads the current flags. Reset values are: command 0, mask 0, status 0, intervals 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register word address |
| wdata | input | DW (32) | Register write data |
| rdata | output | DW (32) | Registered read data for addr |
| underrun_i | input | 1 | Underrun event strobe |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data-enable, polarity applied |
| x_o | output | W (12) | Pixel column in active area |
| y_o | output | W (12) | Pixel row in active area |
| pclk_pol_o | output | 1 | Pixel clock polarity selection |
| data_pol_o | output | 1 | Data polarity selection |
| irq_o | output | 1 | Level interrupt |

## Verification
Suppose one axis counter drifts by a single step or slips an interval. The sync or data-enable edges then land off the expected clock within the first line. A vertical error appears by the end of the first frame, which is a few dozen clocks with small programmed lengths. A status flag that is set wrongly or never cleared shows on irq_o in the clock after the register update, or on the next status read. A counter that keeps its old value across a disable shows as a shifted first frame once the raster is enabled again.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  typedef enum logic [1:0] {
    PH_SYNC   = 2'd0,
    PH_BACK   = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_FRONT  = 2'd3
  } phase_e;

  localparam int NUM_PHASES = 4;
  localparam int NUM_AXES   = 2;
  localparam int POL_BITS   = 5;
  localparam int IRQ_BITS   = 2;

  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_POL  = 4'h1;
  localparam logic [3:0] A_MASK = 4'h2;
  localparam logic [3:0] A_STAT = 4'h3;
  localparam logic [3:0] A_CLR  = 4'h4;

  localparam int POL_HS   = 0;
  localparam int POL_VS   = 1;
  localparam int POL_DE   = 2;
  localparam int POL_PCLK = 3;
  localparam int POL_DATA = 4;

  localparam int IRQ_VS  = 0;
  localparam int IRQ_UND = 1;
endpackage

// File: rtl/vtg_axis.sv
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int W = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr,
  input  logic                         step,
  input  logic [NUM_PHASES-1:0][W-1:0] len,
  output phase_e                       phase_o,
  output logic [W-1:0]                 cnt_o,
  output logic                         wrap_o
);
  phase_e       phase_q;
  logic [W-1:0] cnt_q;
  logic         last;

  assign last   = cnt_q >= len[phase_q];
  assign wrap_o = step && last && (phase_q == PH_FRONT);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= PH_SYNC;
      cnt_q   <= '0;
    end else if (step) begin
      if (last) begin
        phase_q <= phase_e'(phase_q + 2'd1);
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R1: the phase only moves to the next interval or back to sync
  assert_phase_order_R1: assert property (@(posedge clk) disable iff (rst)
    (phase_q != $past(phase_q)) |-> ((phase_q == phase_e'($past(phase_q) + 2'd1)) || (phase_q == PH_SYNC)));

  // R4: a cleared axis restarts at the first clock of sync
  assert_clear_restart_R4: assert property (@(posedge clk) disable iff (rst)
    clr |=> (phase_q == PH_SYNC && cnt_q == '0));
endmodule

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int W  = 12
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic [AW-1:0]                             addr,
  input  logic [DW-1:0]                             wdata,
  input  logic [IRQ_BITS-1:0]                       evt,
  output logic                                      en_o,
  output logic [POL_BITS-1:0]                       pol_o,
  output logic [NUM_AXES-1:0][NUM_PHASES-1:0][W-1:0] tim_o,
  output logic [DW-1:0]                             rdata,
  output logic                                      irq_o
);
  logic                                       ctrl_q;
  logic [POL_BITS-1:0]                        pol_q;
  logic [IRQ_BITS-1:0]                        mask_q, stat_q, clr_bits;
  logic [NUM_AXES-1:0][NUM_PHASES-1:0][W-1:0] tim_q;
  logic [DW-1:0]                              rd_mux;
  logic                                       unused_wdata;

  assign unused_wdata = ^wdata;
  assign clr_bits = (wr_en && addr == AW'(A_CLR)) ? wdata[IRQ_BITS-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    if (addr[3]) rd_mux = DW'(tim_q[addr[2]][addr[1:0]]);
    else begin
      case (addr)
        AW'(A_CTRL): rd_mux = DW'(ctrl_q);
        AW'(A_POL):  rd_mux = DW'(pol_q);
        AW'(A_MASK): rd_mux = DW'(mask_q);
        AW'(A_STAT): rd_mux = DW'(stat_q);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= 1'b0;
      pol_q  <= '1;
      mask_q <= '0;
      stat_q <= '0;
      tim_q  <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        if (addr[3]) tim_q[addr[2]][addr[1:0]] <= wdata[W-1:0];
        else begin
          case (addr)
            AW'(A_CTRL): ctrl_q <= wdata[0];
            AW'(A_POL):  pol_q  <= wdata[POL_BITS-1:0];
            AW'(A_MASK): mask_q <= wdata[IRQ_BITS-1:0];
            default: ;
          endcase
        end
      end
      stat_q <= (stat_q & ~clr_bits) | evt;
      rdata  <= rd_mux;
    end
  end

  assign en_o  = ctrl_q;
  assign pol_o = pol_q;
  assign tim_o = tim_q;
  assign irq_o = |(stat_q & mask_q);

  // R7: an event in the same clock as a clear keeps the bit set
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
    evt[IRQ_UND] |=> stat_q[IRQ_UND]);

  // R6: the vertical sync event always lands in status
  assert_vs_status_R6: assert property (@(posedge clk) disable iff (rst)
    evt[IRQ_VS] |=> stat_q[IRQ_VS]);

  // R8: a full clear with no new event drops the interrupt
  assert_irq_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_bits == '1 && evt == '0) |=> !irq_o);
endmodule

// File: rtl/vtg_top.sv
module vtg_top
  import vtg_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32,
  parameter int W  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          underrun_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [W-1:0]  x_o,
  output logic [W-1:0]  y_o,
  output logic          pclk_pol_o,
  output logic          data_pol_o,
  output logic          irq_o
);
  logic                                       en;
  logic [POL_BITS-1:0]                        pol;
  logic [NUM_AXES-1:0][NUM_PHASES-1:0][W-1:0] tim;
  phase_e                                     phase [NUM_AXES];
  logic [W-1:0]                               cnt   [NUM_AXES];
  logic [NUM_AXES-1:0]                        step, wrap;
  logic                                       vs_evt, de_n;
  logic                                       hs_q, vs_q, de_q;
  logic [W-1:0]                               x_q, y_q;

  assign step[0] = 1'b1;
  assign step[1] = wrap[0];

  for (genvar g = 0; g < NUM_AXES; g++) begin : g_axis
    vtg_axis #(.W(W)) u_axis (
      .clk     (clk),
      .rst     (rst),
      .clr     (~en),
      .step    (step[g]),
      .len     (tim[g]),
      .phase_o (phase[g]),
      .cnt_o   (cnt[g]),
      .wrap_o  (wrap[g])
    );
  end

  assign vs_evt = en && phase[0] == PH_SYNC && cnt[0] == '0
                     && phase[1] == PH_SYNC && cnt[1] == '0;
  assign de_n   = en && phase[0] == PH_ACTIVE && phase[1] == PH_ACTIVE;

  vtg_regs #(.AW(AW), .DW(DW), .W(W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .evt   ({underrun_i, vs_evt}),
    .en_o  (en),
    .pol_o (pol),
    .tim_o (tim),
    .rdata (rdata),
    .irq_o (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
      de_q <= 1'b0;
      x_q  <= '0;
      y_q  <= '0;
    end else begin
      hs_q <= en && phase[0] == PH_SYNC;
      vs_q <= en && phase[1] == PH_SYNC;
      de_q <= de_n;
      x_q  <= de_n ? cnt[0] : '0;
      y_q  <= de_n ? cnt[1] : '0;
    end
  end

  assign hsync_o    = hs_q ~^ pol[POL_HS];
  assign vsync_o    = vs_q ~^ pol[POL_VS];
  assign de_o       = de_q ~^ pol[POL_DE];
  assign x_o        = x_q;
  assign y_o        = y_q;
  assign pclk_pol_o = pol[POL_PCLK];
  assign data_pol_o = pol[POL_DATA];

  // R4: a disabled raster leaves every timing output inactive
  assert_disabled_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!hs_q && !vs_q && !de_q && x_q == '0));

  // R3: inside one active run the column steps by one
  assert_x_step_R3: assert property (@(posedge clk) disable iff (rst)
    (de_q && $past(de_q)) |-> (x_q == $past(x_q) + 1'b1));

  // R6: the frame wrap leads straight into the vertical sync event
  assert_frame_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (wrap[1] && en) |=> (vs_evt || !en));
endmodule

// File: tb/sim_vtg_top.sv
module sim_vtg_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          underrun_i = 1'b0;
  logic          hsync_o, vsync_o, de_o, pclk_pol_o, data_pol_o, irq_o;
  logic [W-1:0]  x_o, y_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wr_edge = 0;
  int hl [4];
  int vl [4];
  logic [4:0] pol_m = 5'h1F;

  vtg_top u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .underrun_i(underrun_i), .hsync_o(hsync_o),
    .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
    .pclk_pol_o(pclk_pol_o), .data_pol_o(data_pol_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_edge = cyc;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic program_timing(input int h0, input int h1, input int h2, input int h3,
                                input int v0, input int v1, input int v2, input int v3);
    hl[0] = h0; hl[1] = h1; hl[2] = h2; hl[3] = h3;
    vl[0] = v0; vl[1] = v1; vl[2] = v2; vl[3] = v3;
    for (int i = 0; i < 4; i++) begin
      wr(4'(8 + i), 32'(hl[i]));
      wr(4'(12 + i), 32'(vl[i]));
    end
  endtask

  task automatic expect_idle(input string req);
    chk(hsync_o == ~pol_m[0], req, "idle hsync", hsync_o, ~pol_m[0]);
    chk(vsync_o == ~pol_m[1], req, "idle vsync", vsync_o, ~pol_m[1]);
    chk(de_o == ~pol_m[2], req, "idle de", de_o, ~pol_m[2]);
    chk(x_o == 0 && y_o == 0, req, "idle xy", {x_o, y_o}, 0);
  endtask

  // called right after the enabling write; walks the raster for n clocks
  task automatic check_raster(input int n, input string req);
    int hs, hb, ha, hlen, vs, vb, va, vlen, t, hp, ln;
    bit ha_act, va_act, h_s, v_s, d;
    hs = hl[0] + 1; hb = hl[1] + 1; ha = hl[2] + 1; hlen = hs + hb + ha + hl[3] + 1;
    vs = vl[0] + 1; vb = vl[1] + 1; va = vl[2] + 1; vlen = vs + vb + va + vl[3] + 1;
    expect_idle(req);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      t  = k - 1;
      hp = t % hlen;
      ln = (t / hlen) % vlen;
      h_s = hp < hs;
      v_s = ln < vs;
      ha_act = hp >= hs + hb && hp < hs + hb + ha;
      va_act = ln >= vs + vb && ln < vs + vb + va;
      d = ha_act && va_act;
      chk(hsync_o == (h_s ~^ pol_m[0]), req, $sformatf("hsync t=%0d", t), hsync_o, h_s ~^ pol_m[0]);
      chk(vsync_o == (v_s ~^ pol_m[1]), req, $sformatf("vsync t=%0d", t), vsync_o, v_s ~^ pol_m[1]);
      chk(de_o == (d ~^ pol_m[2]), "R3", $sformatf("de t=%0d", t), de_o, d ~^ pol_m[2]);
      chk(x_o == (d ? W'(hp - hs - hb) : '0), "R3", $sformatf("x t=%0d", t), x_o, d ? hp - hs - hb : 0);
      chk(y_o == (d ? W'(ln - vs - vb) : '0), "R3", $sformatf("y t=%0d", t), y_o, d ? ln - vs - vb : 0);
    end
  endtask

  task automatic test_reset;
    chk(hsync_o == 0 && vsync_o == 0 && de_o == 0, "R9", "reset sync/de", {hsync_o, vsync_o, de_o}, 0);
    chk(irq_o == 0, "R9", "reset irq", irq_o, 0);
    chk(pclk_pol_o == 1 && data_pol_o == 1, "R5", "reset pol outs", {pclk_pol_o, data_pol_o}, 3);
  endtask

  task automatic test_raster_high;
    program_timing(1, 0, 3, 0, 0, 0, 2, 0);
    wr(4'h0, 1);
    check_raster(2 * 8 * 6 + 5, "R1");
    wr(4'h0, 0);
  endtask

  task automatic test_raster_low;
    logic [31:0] d;
    pol_m = 5'b11000;
    wr(4'h1, 32'(pol_m));
    rd(4'h1, d);
    chk(d == 32'h18, "R9", "pol readback", d, 32'h18);
    chk(pclk_pol_o == 1 && data_pol_o == 1, "R5", "pol outs 11", {pclk_pol_o, data_pol_o}, 3);
    program_timing(0, 1, 2, 1, 1, 0, 1, 0);
    wr(4'h0, 1);
    check_raster(2 * 8 * 6 + 3, "R2");
    wr(4'h0, 0);
    pol_m = 5'b00111;
    wr(4'h1, 32'(pol_m));
    @(negedge clk);
    chk(pclk_pol_o == 0 && data_pol_o == 0, "R5", "pol outs 00", {pclk_pol_o, data_pol_o}, 0);
    expect_idle("R5");
  endtask

  task automatic test_disable;
    program_timing(1, 0, 3, 0, 0, 0, 2, 0);
    wr(4'h0, 1);
    repeat (29) @(negedge clk);
    wr(4'h0, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expect_idle("R4");
    end
    wr(4'h0, 1);
    check_raster(60, "R4");
  endtask

  task automatic test_vsync_irq;
    logic [31:0] d;
    int e;
    wr(4'h0, 0);
    wr(4'h4, 3);
    wr(4'h2, 1);
    @(negedge clk);
    chk(irq_o == 0, "R8", "irq before enable", irq_o, 0);
    wr(4'h0, 1);
    e = wr_edge;
    chk(irq_o == 0, "R6", "irq at enable edge", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1, "R6", "irq on first vsync clock", irq_o, 1);
    rd(4'h3, d);
    chk(d[0] == 1, "R6", "vsync status bit", d[0], 1);
    wr(4'h4, 1);
    @(negedge clk);
    chk(irq_o == 0, "R7", "irq after clear", irq_o, 0);
    while (cyc < e + 48) @(negedge clk);
    chk(irq_o == 0, "R6", "irq before next frame", irq_o, 0);
    @(negedge clk);
    chk(irq_o == 1, "R6", "irq on next frame", irq_o, 1);
    wr(4'h0, 0);
    wr(4'h4, 3);
  endtask

  task automatic test_underrun;
    logic [31:0] d;
    wr(4'h2, 0);
    @(negedge clk); underrun_i = 1'b1;
    @(negedge clk); underrun_i = 1'b0;
    rd(4'h3, d);
    chk(d[1:0] == 2'b10, "R6", "underrun status with mask off", d[1:0], 2);
    chk(irq_o == 0, "R8", "masked irq", irq_o, 0);
    wr(4'h2, 2);
    @(negedge clk);
    chk(irq_o == 1, "R8", "unmasked irq", irq_o, 1);
    @(negedge clk);
    wr_en = 1'b1; addr = 4'h4; wdata = 32'h2; underrun_i = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; underrun_i = 1'b0;
    rd(4'h3, d);
    chk(d[1] == 1, "R7", "event beats clear", d[1], 1);
    wr(4'h4, 32'h1);
    rd(4'h3, d);
    chk(d[1] == 1, "R7", "zero bit of clear leaves flag", d[1], 1);
    wr(4'h4, 32'h2);
    rd(4'h3, d);
    chk(d[1] == 0, "R7", "clear alone", d[1], 0);
    chk(irq_o == 0, "R8", "irq after clear", irq_o, 0);
    wr(4'h2, 0);
  endtask

  task automatic test_readback;
    logic [31:0] d;
    wr(4'hA, 32'h2A5);
    rd(4'hA, d);
    chk(d == 32'h2A5, "R9", "h active readback", d, 32'h2A5);
    wr(4'hF, 32'h7);
    rd(4'hF, d);
    chk(d == 32'h7, "R9", "v front readback", d, 32'h7);
    wr(4'h2, 32'h3);
    rd(4'h2, d);
    chk(d == 32'h3, "R9", "mask readback", d, 3);
    rd(4'h4, d);
    chk(d == 0, "R9", "clear reads zero", d, 0);
    wr(4'h2, 0);
    rd(4'h0, d);
    chk(d == 0, "R9", "command readback", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_raster_high();
    test_raster_low();
    pol_m = 5'h1F;
    wr(4'h1, 32'(pol_m));
    test_disable();
    test_vsync_irq();
    test_underrun();
    test_readback();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule